// File: doc/BRIEF.md
# Dynamic Address Assignment Sequencer

This block runs on the controller side and gives dynamic addresses to target devices one device per round. A round first asks a slot allocator for a free device-table slot, then asks an address pool for a candidate dynamic address. It writes that address into the slot and, in the same cycle, clears the read pointer of the characteristic table. It then issues one 64-bit assignment command descriptor and waits for a response word. If none arrives in time, it asks for the command to be withdrawn.

A plain success response produces an assignment event carrying the address, releases the temporary slot and starts the next round. A NACK or address-header response with data length one means that no device is left, so the run stops cleanly. Any other failure, a timeout or a lack of resources also stops the run. Whenever the block stops, it releases any slot it still holds, then raises `done` for one cycle with a status code. The bus protocol, the pool policy and the table storage all sit outside the block and are reached through simple handshakes.

Top module: `daa_sequencer`

## Requirements
- R1: Each accepted descriptor has these fields. Bits [2:0] = 3'b010, bits [6:3] = transaction tag, bits [14:7] = assignment CCC code (default 8'h07), bits [20:16] = the held slot index, bits [29:26] = 4'd1, and bits 30 and 31 are set. Every other bit, including all of [63:32], is zero.
- R2: The transaction tag is 0 for the first command after reset and rises by one (modulo 16) with each accepted command.
- R3: Before each command, `tbl_wr` pulses for one cycle with the granted slot and candidate address, and `char_idx_clr` is high in that same cycle. `cmd_valid` rises in the next cycle.
- R4: A response with status 4'h0 pulses `assign_evt` with the candidate address. `slot_free` pulses with the held slot in the same cycle, and the next round begins.
- R5: A response with status 4'h5 (NACK) or 4'h4 (address header) and data length exactly 1 releases the slot. `done` then follows with status 2'd0 (clean end).
- R6: Any other non-zero response status releases the slot and ends with status 2'd1 (I/O error). This includes 4'h4 and 4'h5 with a length other than 1.
- R7: The wait counter is zero in the first waiting cycle. If no response has arrived by the waiting cycle whose count equals `timeout_cycles`, `wd_req` rises in the cycle after it. A response in that last waiting cycle is still accepted. If the withdraw acknowledge reports the command still pending, the run ends with status 2'd2 (timeout).
- R8: If the withdraw acknowledge reports the command no longer pending, the block returns to waiting with a fresh count and handles the response normally.
- R9: If a slot grant comes back not-ok, `done` follows with status 2'd3 (no resource) and no `slot_free`. If an address grant comes back not-ok, `slot_free` is pulsed first and `done` follows with status 2'd3.
- R10: After reset, all request, strobe and busy outputs are low. `busy` is high from a start until `done`, and `done` lasts one cycle. `start` has no effect while busy, and every slot granted ok is freed exactly once before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an assignment run when idle |
| timeout_cycles | input | 16 | Waiting-cycle limit before a withdraw |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | Run result, valid with `done` |
| slot_req | output | 1 | Request for a free table slot |
| slot_gnt | input | 1 | Slot request answered |
| slot_ok | input | 1 | Slot answer carries a free slot |
| slot_idx | input | 5 | Granted slot index |
| addr_req | output | 1 | Request for a candidate address |
| addr_gnt | input | 1 | Address request answered |
| addr_ok | input | 1 | Address answer carries a free address |
| addr_val | input | 7 | Candidate dynamic address |
| tbl_wr | output | 1 | Write candidate address into slot |
| char_idx_clr | output | 1 | Clear characteristic-table read index |
| tbl_wr_idx | output | 5 | Slot written |
| tbl_wr_addr | output | 7 | Address written |
| cmd_valid | output | 1 | Descriptor offered |
| cmd_ready | input | 1 | Descriptor taken |
| cmd_desc | output | 64 | Assignment command descriptor |
| rsp_valid | input | 1 | Response word present |
| rsp_status | input | 4 | Response status code |
| rsp_len | input | 16 | Response data length |
| wd_req | output | 1 | Withdraw request for the outstanding command |
| wd_ack | input | 1 | Withdraw answered |
| wd_pending | input | 1 | Command was still pending and is withdrawn |
| assign_evt | output | 1 | One device got an address |
| assign_addr | output | 7 | Address that was assigned |
| slot_free | output | 1 | Release the temporary slot |
| slot_free_idx | output | 5 | Slot released |

## Verification
A response can arrive in exactly the cycle where the wait count reaches `timeout_cycles`, which is also when the timeout would fire. The bench provokes this with a directed response delay equal to the limit and with random delays bounded by it, then expects the response to win: no `wd_req`, and the normal event or ending follows. In a second coincidence, a success response makes the assignment event and the slot release appear in one cycle. The bench judges this by requiring `slot_free` and the right index whenever `assign_evt` is seen, and by counting that each held slot is freed once.

// File: rtl/daa_pkg.sv
package daa_pkg;
    localparam int SLOT_W = 5;
    localparam int ADDR_W = 7;
    localparam int TID_W  = 4;
    localparam int RST_W  = 4;
    localparam int LEN_W  = 16;

    localparam logic [RST_W-1:0] RSP_SUCCESS  = 4'h0;
    localparam logic [RST_W-1:0] RSP_ADDR_HDR = 4'h4;
    localparam logic [RST_W-1:0] RSP_NACK     = 4'h5;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_IO_ERR  = 2'd1,
        ST_TIMEOUT = 2'd2,
        ST_NO_RES  = 2'd3
    } daa_status_e;

    typedef enum logic [3:0] {
        S_IDLE, S_SLOT, S_ADDR, S_PROG, S_ISSUE,
        S_WAIT, S_WDRAW, S_REPORT, S_RELEASE, S_FINISH
    } daa_state_e;

    typedef struct packed {
        daa_state_e        st;
        logic [SLOT_W-1:0] slot;
        logic [ADDR_W-1:0] addr;
        logic [TID_W-1:0]  tid;
        daa_status_e       status;
    } daa_regs_t;
endpackage

// File: rtl/daa_desc_pack.sv
module daa_desc_pack
    import daa_pkg::*;
#(
    parameter logic [7:0] CCC_CODE = 8'h07
) (
    input  logic [TID_W-1:0]  tid,
    input  logic [SLOT_W-1:0] slot,
    output logic [63:0]       desc
);
    always_comb begin
        desc        = '0;
        desc[2:0]   = 3'b010;
        desc[6:3]   = tid;
        desc[14:7]  = CCC_CODE;
        desc[20:16] = slot;
        desc[29:26] = 4'd1;
        desc[30]    = 1'b1;
        desc[31]    = 1'b1;
    end
endmodule

// File: rtl/daa_wait_timer.sv
module daa_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)                cnt_d = '0;
        else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
        else                     cnt_d = cnt_q + 1'b1;
        expired = run && (cnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/daa_sequencer.sv
module daa_sequencer
    import daa_pkg::*;
#(
    parameter int         CNT_W    = 16,
    parameter logic [7:0] CCC_CODE = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  timeout_cycles,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              slot_req,
    input  logic              slot_gnt,
    input  logic              slot_ok,
    input  logic [SLOT_W-1:0] slot_idx,
    output logic              addr_req,
    input  logic              addr_gnt,
    input  logic              addr_ok,
    input  logic [ADDR_W-1:0] addr_val,
    output logic              tbl_wr,
    output logic              char_idx_clr,
    output logic [SLOT_W-1:0] tbl_wr_idx,
    output logic [ADDR_W-1:0] tbl_wr_addr,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [63:0]       cmd_desc,
    input  logic              rsp_valid,
    input  logic [RST_W-1:0]  rsp_status,
    input  logic [LEN_W-1:0]  rsp_len,
    output logic              wd_req,
    input  logic              wd_ack,
    input  logic              wd_pending,
    output logic              assign_evt,
    output logic [ADDR_W-1:0] assign_addr,
    output logic              slot_free,
    output logic [SLOT_W-1:0] slot_free_idx
);
    daa_regs_t r_d, r_q;
    logic      tmo_expired;
    logic      end_code;

    daa_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.st == S_WAIT),
        .limit   (timeout_cycles),
        .expired (tmo_expired)
    );

    daa_desc_pack #(.CCC_CODE(CCC_CODE)) u_pack (
        .tid  (r_q.tid),
        .slot (r_q.slot),
        .desc (cmd_desc)
    );

    assign end_code = ((rsp_status == RSP_NACK) || (rsp_status == RSP_ADDR_HDR))
                      && (rsp_len == LEN_W'(1));

    always_comb begin
        r_d          = r_q;
        slot_req     = 1'b0;
        addr_req     = 1'b0;
        tbl_wr       = 1'b0;
        char_idx_clr = 1'b0;
        cmd_valid    = 1'b0;
        wd_req       = 1'b0;
        assign_evt   = 1'b0;
        slot_free    = 1'b0;
        done         = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.status = ST_OK;
                    r_d.st     = S_SLOT;
                end
            end
            S_SLOT: begin
                slot_req = 1'b1;
                if (slot_gnt) begin
                    if (slot_ok) begin
                        r_d.slot = slot_idx;
                        r_d.st   = S_ADDR;
                    end else begin
                        r_d.status = ST_NO_RES;
                        r_d.st     = S_FINISH;
                    end
                end
            end
            S_ADDR: begin
                addr_req = 1'b1;
                if (addr_gnt) begin
                    if (addr_ok) begin
                        r_d.addr = addr_val;
                        r_d.st   = S_PROG;
                    end else begin
                        r_d.status = ST_NO_RES;
                        r_d.st     = S_RELEASE;
                    end
                end
            end
            S_PROG: begin
                tbl_wr       = 1'b1;
                char_idx_clr = 1'b1;
                r_d.st       = S_ISSUE;
            end
            S_ISSUE: begin
                cmd_valid = 1'b1;
                if (cmd_ready) begin
                    r_d.tid = r_q.tid + 1'b1;
                    r_d.st  = S_WAIT;
                end
            end
            S_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_status == RSP_SUCCESS) begin
                        r_d.st = S_REPORT;
                    end else begin
                        r_d.status = end_code ? ST_OK : ST_IO_ERR;
                        r_d.st     = S_RELEASE;
                    end
                end else if (tmo_expired) begin
                    r_d.st = S_WDRAW;
                end
            end
            S_WDRAW: begin
                wd_req = 1'b1;
                if (wd_ack) begin
                    if (wd_pending) begin
                        r_d.status = ST_TIMEOUT;
                        r_d.st     = S_RELEASE;
                    end else begin
                        r_d.st = S_WAIT;
                    end
                end
            end
            S_REPORT: begin
                assign_evt = 1'b1;
                slot_free  = 1'b1;
                r_d.st     = S_SLOT;
            end
            S_RELEASE: begin
                slot_free = 1'b1;
                r_d.st    = S_FINISH;
            end
            S_FINISH: begin
                done   = 1'b1;
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= S_IDLE;
            r_q.slot   <= '0;
            r_q.addr   <= '0;
            r_q.tid    <= '0;
            r_q.status <= ST_OK;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy          = (r_q.st != S_IDLE);
    assign status        = r_q.status;
    assign tbl_wr_idx    = r_q.slot;
    assign tbl_wr_addr   = r_q.addr;
    assign slot_free_idx = r_q.slot;
    assign assign_addr   = r_q.addr;
endmodule

// File: rtl/daa_sequencer_chk.sv
module daa_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        slot_req,
    input logic        addr_req,
    input logic        tbl_wr,
    input logic        char_idx_clr,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [63:0] cmd_desc,
    input logic        wd_req,
    input logic        wd_ack,
    input logic        assign_evt,
    input logic        slot_free
);
    p_desc_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_desc[63:32] == 32'h0) && (cmd_desc[2:0] == 3'b010)
                      && (cmd_desc[31:30] == 2'b11) && (cmd_desc[29:26] == 4'd1));

    p_desc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_desc));

    p_prog_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(tbl_wr));

    p_clr_with_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr |-> char_idx_clr);

    p_evt_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        assign_evt |-> slot_free);

    p_wd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_req && !wd_ack |=> wd_req);

    p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({slot_req, addr_req, tbl_wr, cmd_valid, wd_req, done}));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind daa_sequencer daa_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .slot_req     (slot_req),
    .addr_req     (addr_req),
    .tbl_wr       (tbl_wr),
    .char_idx_clr (char_idx_clr),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_desc     (cmd_desc),
    .wd_req       (wd_req),
    .wd_ack       (wd_ack),
    .assign_evt   (assign_evt),
    .slot_free    (slot_free)
);

// File: tb/tb_daa_sequencer.sv
`timescale 1ns/1ps
module tb_daa_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] timeout_cycles = 16'd4;
    logic        busy, done;
    logic [1:0]  status;
    logic        slot_req, addr_req, tbl_wr, char_idx_clr, cmd_valid, wd_req;
    logic        slot_gnt = 1'b0, slot_ok = 1'b0;
    logic [4:0]  slot_idx = '0;
    logic        addr_gnt = 1'b0, addr_ok = 1'b0;
    logic [6:0]  addr_val = '0;
    logic [4:0]  tbl_wr_idx, slot_free_idx;
    logic [6:0]  tbl_wr_addr, assign_addr;
    logic        cmd_ready = 1'b0;
    logic [63:0] cmd_desc;
    logic        rsp_valid = 1'b0;
    logic [3:0]  rsp_status = '0;
    logic [15:0] rsp_len = '0;
    logic        wd_ack = 1'b0, wd_pending = 1'b0;
    logic        assign_evt, slot_free;

    int nchecks = 0;
    int nfail   = 0;
    int T;
    int p_sok[8], p_aok[8], p_kind[8], p_delay[8];
    logic [3:0] tid_exp = 4'd0;

    always #2.5 clk = ~clk;

    daa_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .timeout_cycles(timeout_cycles),
        .busy(busy), .done(done), .status(status),
        .slot_req(slot_req), .slot_gnt(slot_gnt), .slot_ok(slot_ok), .slot_idx(slot_idx),
        .addr_req(addr_req), .addr_gnt(addr_gnt), .addr_ok(addr_ok), .addr_val(addr_val),
        .tbl_wr(tbl_wr), .char_idx_clr(char_idx_clr), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_addr(tbl_wr_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_desc(cmd_desc), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_len(rsp_len), .wd_req(wd_req), .wd_ack(wd_ack), .wd_pending(wd_pending),
        .assign_evt(assign_evt), .assign_addr(assign_addr), .slot_free(slot_free),
        .slot_free_idx(slot_free_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_desc(input logic [3:0] tid, input logic [4:0] idx);
        logic [63:0] w;
        w = '0;
        w[2:0] = 3'b010;  w[6:3] = tid;   w[14:7] = 8'h07;
        w[20:16] = idx;   w[29:26] = 4'd1; w[30] = 1'b1; w[31] = 1'b1;
        return w;
    endfunction

    // kinds: 0 success, 1 nack len1, 2 hdr len1, 3 other error, 4 nack/hdr bad len,
    //        5 timeout still pending, 6 timeout not pending then success
    task automatic exp_outcome(input int n, output int xs, output int xa);
        xa = 0; xs = 1;
        for (int i = 0; i < n; i++) begin
            if (p_sok[i] == 0 || p_aok[i] == 0) begin xs = 3; return; end
            case (p_kind[i])
                0, 6:    xa++;
                1, 2:    begin xs = 0; return; end
                3, 4:    begin xs = 1; return; end
                default: begin xs = 2; return; end
            endcase
        end
    endtask

    task automatic set_round(input int i, input int sok, input int aok,
                             input int kind, input int dly);
        p_sok[i] = sok; p_aok[i] = aok; p_kind[i] = kind; p_delay[i] = dly;
    endtask

    task automatic drive_rsp(input int kind);
        rsp_valid = 1'b1;
        case (kind)
            0, 6: begin rsp_status = 4'h0; rsp_len = 16'($urandom % 9); end
            1:    begin rsp_status = 4'h5; rsp_len = 16'd1; end
            2:    begin rsp_status = 4'h4; rsp_len = 16'd1; end
            3:    begin
                rsp_status = 4'(1 + $urandom % 15);
                if (rsp_status == 4'h4 || rsp_status == 4'h5) rsp_status = 4'h9;
                rsp_len = 16'd1;
            end
            default: begin
                rsp_status = ($urandom % 2 == 0) ? 4'h4 : 4'h5;
                rsp_len = ($urandom % 2 == 0) ? 16'd0 : 16'(2 + $urandom % 5);
            end
        endcase
    endtask

    task automatic run_scn(input int n);
        int r = 0, held = 0, nassign = 0, wk = 0, cyc, xs, xa;
        bit armed = 0, post_wd = 0, wd_checked = 0;
        logic [4:0] cs = '0;
        logic [6:0] ca = '0;
        string tag;
        exp_outcome(n, xs, xa);
        tag = (xs == 0) ? "R5" : (xs == 1) ? "R6" : (xs == 2) ? "R7" : "R9";
        timeout_cycles = 16'(T);
        @(negedge clk);
        start = 1'b1;
        for (cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            start = 1'b0; slot_gnt = 1'b0; addr_gnt = 1'b0; rsp_valid = 1'b0;
            wd_ack = 1'b0; cmd_ready = 1'b0;
            if (busy && ($urandom % 8 == 0)) start = 1'b1;
            if (post_wd) begin drive_rsp(0); post_wd = 0; end
            if (armed) begin
                if (p_kind[r] == 5 || p_kind[r] == 6) begin
                    if (!wd_checked && wk == T)
                        chk(!wd_req, "R7", "withdraw too early", 64'(wd_req), 64'd0);
                    if (!wd_checked && wk == T + 1) begin
                        chk(wd_req, "R7", "withdraw after limit", 64'(wd_req), 64'd1);
                        wd_checked = 1;
                    end
                end else if (wk == p_delay[r]) begin
                    drive_rsp(p_kind[r]);
                    armed = 0;
                end
                wk++;
            end
            if (wd_req && ($urandom % 2 == 0)) begin
                wd_ack = 1'b1;
                wd_pending = (p_kind[r] == 5);
                armed = 0;
                if (p_kind[r] == 6) post_wd = 1;  // R8 resume path
            end
            if (slot_req && ($urandom % 2 == 0)) begin
                slot_gnt = 1'b1;
                slot_ok = (p_sok[r] != 0);
                slot_idx = 5'($urandom);
                if (slot_ok) begin cs = slot_idx; held++; end
            end
            if (addr_req && ($urandom % 2 == 0)) begin
                addr_gnt = 1'b1;
                addr_ok = (p_aok[r] != 0);
                addr_val = 7'($urandom);
                if (addr_ok) ca = addr_val;
            end
            if (tbl_wr) begin
                chk(tbl_wr_idx == cs && tbl_wr_addr == ca && char_idx_clr, "R3",
                    "table write", {tbl_wr_idx, tbl_wr_addr, char_idx_clr},
                    {cs, ca, 1'b1});
            end
            if (cmd_valid && ($urandom % 2 == 0)) begin
                cmd_ready = 1'b1;
                chk(cmd_desc == exp_desc(tid_exp, cs), "R1/R2", "descriptor",
                    cmd_desc, exp_desc(tid_exp, cs));
                tid_exp = tid_exp + 4'd1;
                armed = 1; wk = 0; wd_checked = 0;
            end
            if (assign_evt) begin
                chk(assign_addr == ca, "R4", "assigned address", 64'(assign_addr), 64'(ca));
                chk(slot_free && slot_free_idx == cs, "R4", "release with event",
                    {slot_free, slot_free_idx}, {1'b1, cs});
                nassign++; held--; r++;
            end else if (slot_free) begin
                chk(slot_free_idx == cs, "R9", "released slot", 64'(slot_free_idx), 64'(cs));
                held--;
            end
            if (done) begin
                chk(status == 2'(xs), tag, "end status", 64'(status), 64'(xs));
                chk(nassign == xa, "R4", "assignment count", 64'(nassign), 64'(xa));
                chk(held == 0, "R10", "slots left held", 64'(held), 64'd0);
                break;
            end
        end
        if (cyc >= 3000) chk(1'b0, "R10", "run never finished", 64'd0, 64'd1);
        start = 1'b0; slot_gnt = 1'b0; addr_gnt = 1'b0; rsp_valid = 1'b0;
        wd_ack = 1'b0; cmd_ready = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R10", "idle after done, start ignored",
            {busy, done}, 64'd0);
    endtask

    initial begin
        #(5ns * 190000);
        chk(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !slot_req && !cmd_valid && !wd_req && !tbl_wr && !assign_evt
            && !slot_free, "R10", "reset state",
            {busy, done, slot_req, cmd_valid, wd_req, tbl_wr, assign_evt, slot_free}, 64'd0);
        rst_n = 1'b1;
        // directed: success at the exact limit, then clean NACK end
        T = 4; set_round(0, 1, 1, 0, 4); set_round(1, 1, 1, 1, 0); run_scn(2);
        // address-header with length one at once
        T = 0; set_round(0, 1, 1, 2, 0); run_scn(1);
        // no slot
        T = 3; set_round(0, 0, 1, 0, 0); run_scn(1);
        // slot then no address
        T = 3; set_round(0, 1, 1, 0, 1); set_round(1, 1, 0, 0, 0); run_scn(2);
        // timeout with command still pending
        T = 2; set_round(0, 1, 1, 5, 0); run_scn(1);
        // timeout, not pending, resume, then NACK end
        T = 1; set_round(0, 1, 1, 6, 0); set_round(1, 1, 1, 1, 1); run_scn(2);
        // plain error and end codes with bad length
        T = 5; set_round(0, 1, 1, 3, 2); run_scn(1);
        T = 5; set_round(0, 1, 1, 4, 5); run_scn(1);
        // random runs
        for (int s = 0; s < 40; s++) begin
            T = $urandom % 7;
            n = 1 + $urandom % 4;
            for (int i = 0; i < n - 1; i++)
                set_round(i, 1, 1, ($urandom % 3 == 0) ? 6 : 0, $urandom % (T + 1));
            case ($urandom % 7)
                0:       set_round(n - 1, 0, 1, 1, 0);
                1:       set_round(n - 1, 1, 0, 1, 0);
                default: set_round(n - 1, 1, 1, 1 + $urandom % 5, $urandom % (T + 1));
            endcase
            run_scn(n);
        end
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule